// File: doc/BRIEF.md
# Interrupt Request Acknowledge Sequencer

This block sits between a processor core and its external bus. It watches two interrupt request inputs. One is non-maskable and edge-sensitive. The other is maskable and level-sensitive, and is gated by the core's interrupt-enable flag. The block picks which request to serve. A non-maskable request is answered inside the block with a fixed vector number and uses no bus cycle. A maskable request starts one or two acknowledge bus cycles. During those cycles the address bus is floated, an active-low acknowledge strobe is pulsed, and the interrupting device places an 8-bit vector type on the data bus.

A mode input chooses between two variants. In the single variant there is one acknowledge cycle, and the type is read during it. In the double variant there are two back-to-back acknowledge cycles with an active-low bus lock held across both, and the type is read only in the second cycle. In every case the resulting vector type goes back to the core together with a one-clock valid strobe.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ack_n` and `lock_n` are 1, and `addr_float` and `vec_valid` are 0.
- R2: A rising edge on `nmi_in` yields exactly one `vec_valid` pulse with `vec_type` = 2. No acknowledge cycle runs for it, and a level held high does not retrigger.
- R3: `intr_in` starts an acknowledge sequence only while `ie_flag` is 1. When `ie_flag` is 0, a high `intr_in` produces no acknowledge strobe and no vector.
- R4: When both requests are pending in the same cycle, the non-maskable vector is delivered first and the maskable sequence follows.
- R5: A non-maskable pulse of one clock that arrives during an acknowledge sequence is held and served once the sequence ends.
- R6: An acknowledge cycle lasts four clocks (T1..T4). `addr_float` is 1 in all four and 0 when idle.
- R7: `ack_n` falls at the start of T2, stays low for exactly two clocks (T2, T3), and is high again in T4.
- R8: With `dual_mode` = 0, one acknowledge cycle runs. `data_in` is sampled at the end of T3, and `vec_valid` is 1 during T4.
- R9: With `dual_mode` = 1, two acknowledge cycles run back to back. Only `data_in` from the second cycle is returned, and `vec_valid` is 1 during the second T4.
- R10: With `dual_mode` = 1, `lock_n` is 0 for all eight clocks of both cycles. With `dual_mode` = 0, it stays 1.
- R11: `vec_valid` is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive, asynchronous |
| intr_in | input | 1 | Maskable request, level sensitive, asynchronous |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| dual_mode | input | 1 | 0: one acknowledge cycle, 1: two locked cycles |
| data_in | input | TYPE_W | Data bus, carries the vector type |
| ack_n | output | 1 | Active-low acknowledge strobe |
| lock_n | output | 1 | Active-low bus lock |
| addr_float | output | 1 | 1 while the address bus must be floated |
| vec_type | output | TYPE_W | Vector type returned to the core |
| vec_valid | output | 1 | One-clock strobe qualifying `vec_type` |

## Verification
The bench drives several patterns:
- Single and double maskable sequences, each carrying a distinct type. In the double case the data bus holds a decoy value during the first cycle, which shows whether the type is sampled from the right cycle.
- A one-clock non-maskable pulse, and a long held level, which separate edge sensitivity from level sensitivity.
- A masked request held for thirty clocks, which shows whether the enable gate works.
- Both requests raised together, and a short non-maskable pulse during a locked sequence, which expose errors in priority and latching.

For every vector, the monitor counts acknowledge, lock and float clocks, and these counts pin down the cycle structure.

// File: rtl/irq_ack_pkg.sv
// Shared types for the interrupt acknowledge sequencer.
package irq_ack_pkg;
    // Bus state of one acknowledge cycle; BUS_IDLE means no cycle running.
    typedef enum logic [2:0] {
        BUS_IDLE = 3'd0,
        BUS_T1   = 3'd1,
        BUS_T2   = 3'd2,
        BUS_T3   = 3'd3,
        BUS_T4   = 3'd4
    } bus_state_e;
endpackage

// File: rtl/irq_sync.sv
// irq_sync: synchronizes an asynchronous level into clk.
// Assumes: STAGES = 0 means the input is already synchronous.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} ;
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_req_capture.sv
// irq_req_capture: turns raw request pins into pending requests.
// The non-maskable input is edge-detected and held until it is served.
// The maskable input is a level qualified by the enable flag.
// Assumes: take_nmi is asserted for one clock when the non-maskable
// request is served.
module irq_req_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic intr_in,
    input  logic ie_flag,
    input  logic take_nmi,
    output logic nmi_req,
    output logic intr_req
);
    logic nmi_s;
    logic intr_s;
    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_rise;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(nmi_s)
    );
    irq_sync #(.STAGES(SYNC_STAGES)) u_sync_intr (
        .clk(clk), .rst_n(rst_n), .d(intr_in), .q(intr_s)
    );

    assign nmi_rise = nmi_s & ~nmi_prev_q;
    assign nmi_req  = nmi_pend_q | nmi_rise;
    assign intr_req = intr_s & ie_flag;

    // Keep the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev_q <= 1'b0;
        else        nmi_prev_q <= nmi_s;
    end

    // Hold a detected edge until the sequencer serves it.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend_q <= 1'b0;
        else        nmi_pend_q <= nmi_req & ~take_nmi;
    end
endmodule

// File: rtl/irq_bus_fsm.sv
// irq_bus_fsm: arbitrates pending requests and steps the T-states
// of the acknowledge cycles.
// Non-maskable requests win and are answered without a bus cycle.
// In double mode, two cycles run back to back under lock.
// Assumes: requests are synchronous to clk; no wait states are inserted.
module irq_bus_fsm
    import irq_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic intr_req,
    input  logic dual_mode,
    output logic take_nmi,
    output logic capture_en,
    output logic ack_n,
    output logic lock_n,
    output logic addr_float
);
    bus_state_e state_q;
    bus_state_e state_d;
    logic       dual_q;
    logic       second_q;
    logic       idle;
    logic       start_ack;

    assign idle      = (state_q == BUS_IDLE);
    assign take_nmi  = idle & nmi_req;
    assign start_ack = idle & ~nmi_req & intr_req;

    // Next-state selection for the T-state walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (start_ack) state_d = BUS_T1;
            BUS_T1:   state_d = BUS_T2;
            BUS_T2:   state_d = BUS_T3;
            BUS_T3:   state_d = BUS_T4;
            BUS_T4:   state_d = (dual_q && !second_q) ? BUS_T1 : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Latch the mode at sequence start and track which cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_q   <= 1'b0;
            second_q <= 1'b0;
        end else if (start_ack) begin
            dual_q   <= dual_mode;
            second_q <= 1'b0;
        end else if (state_q == BUS_T4) begin
            second_q <= dual_q & ~second_q;
        end
    end

    assign capture_en = (state_q == BUS_T3) & (second_q | ~dual_q);
    assign ack_n      = ~((state_q == BUS_T2) | (state_q == BUS_T3));
    assign lock_n     = ~(dual_q & ~idle);
    assign addr_float = ~idle;
endmodule

// File: rtl/irq_vec_reg.sv
// irq_vec_reg: holds the vector type returned to the core and pulses
// its valid strobe for one clock.
// Assumes: take_nmi and capture_en are never high together.
module irq_vec_reg #(
    parameter int TYPE_W  = 8,
    parameter int NMI_VEC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_nmi,
    input  logic              capture_en,
    input  logic [TYPE_W-1:0] data_in,
    output logic [TYPE_W-1:0] vec_type,
    output logic              vec_valid
);
    localparam logic [TYPE_W-1:0] NmiCode = TYPE_W'(NMI_VEC);

    // Load the fixed or bus-supplied type and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_type  <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= take_nmi | capture_en;
            if (take_nmi)        vec_type <= NmiCode;
            else if (capture_en) vec_type <= data_in;
        end
    end
endmodule

// File: rtl/irq_ack_seq.sv
// irq_ack_seq: top of the interrupt acknowledge sequencer.
// It joins request capture, the bus state walker and the vector register.
// Assumes: the external bus is free whenever this block leaves idle.
module irq_ack_seq #(
    parameter int TYPE_W      = 8,
    parameter int NMI_VEC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              intr_in,
    input  logic              ie_flag,
    input  logic              dual_mode,
    input  logic [TYPE_W-1:0] data_in,
    output logic              ack_n,
    output logic              lock_n,
    output logic              addr_float,
    output logic [TYPE_W-1:0] vec_type,
    output logic              vec_valid
);
    logic nmi_req;
    logic intr_req;
    logic take_nmi;
    logic capture_en;

    irq_req_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .intr_in(intr_in),
        .ie_flag(ie_flag), .take_nmi(take_nmi),
        .nmi_req(nmi_req), .intr_req(intr_req)
    );

    irq_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .intr_req(intr_req),
        .dual_mode(dual_mode), .take_nmi(take_nmi), .capture_en(capture_en),
        .ack_n(ack_n), .lock_n(lock_n), .addr_float(addr_float)
    );

    irq_vec_reg #(.TYPE_W(TYPE_W), .NMI_VEC(NMI_VEC)) u_vec (
        .clk(clk), .rst_n(rst_n), .take_nmi(take_nmi),
        .capture_en(capture_en), .data_in(data_in),
        .vec_type(vec_type), .vec_valid(vec_valid)
    );
endmodule

// File: rtl/irq_ack_chk.sv
// irq_ack_chk: port-level properties of irq_ack_seq, attached by bind.
module irq_ack_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_n,
    input logic lock_n,
    input logic addr_float,
    input logic vec_valid
);
    // R1: outputs idle right after a reset clock.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ack_n && lock_n && !addr_float && !vec_valid));

    // R7: strobe stays low for a second clock once it falls.
    a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |=> !ack_n);

    // R7: after two low clocks the strobe is released.
    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |=> ack_n);

    // R6: the address bus is floated whenever the strobe is active.
    a_r6_float_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> addr_float);

    // R6: a new cycle begins with T1, strobe still high, then T2 low.
    a_r6_t1_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_float) |-> ack_n ##1 !ack_n);

    // R10: lock only appears inside an acknowledge sequence.
    a_r10_lock_inside: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> addr_float);

    // R11: valid is a single-clock pulse.
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
endmodule

bind irq_ack_seq irq_ack_chk u_irq_ack_chk (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .lock_n(lock_n),
    .addr_float(addr_float), .vec_valid(vec_valid)
);

// File: tb/tb_irq_ack_seq.sv
`timescale 1ns/1ps
module tb_irq_ack_seq;
    typedef struct {
        logic [7:0] typ;
        int         runs;
        int         ackc;
        int         lockc;
        int         fltc;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_in = 1'b0;
    logic       intr_in = 1'b0;
    logic       ie_flag = 1'b1;
    logic       dual_mode = 1'b0;
    logic [7:0] data_in;
    logic       ack_n;
    logic       lock_n;
    logic       addr_float;
    logic [7:0] vec_type;
    logic       vec_valid;

    exp_t       exp_q[$];
    int         checks = 0;
    int         errors = 0;
    int         mon_runs = 0;
    int         mon_ack = 0;
    int         mon_lock = 0;
    int         mon_flt = 0;
    int         total_falls = 0;
    int         need_runs = 1;
    logic [7:0] good_type = 8'h00;
    logic       prev_ack = 1'b1;
    logic       prev_valid = 1'b0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    // Decoy value until the cycle that must supply the type.
    assign data_in = (mon_runs >= need_runs) ? good_type : 8'hEE;

    irq_ack_seq dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .intr_in(intr_in),
        .ie_flag(ie_flag), .dual_mode(dual_mode), .data_in(data_in),
        .ack_n(ack_n), .lock_n(lock_n), .addr_float(addr_float),
        .vec_type(vec_type), .vec_valid(vec_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // mode: 0 non-maskable, 1 single cycle, 2 double cycle
    task automatic push_exp(input logic [7:0] t, input int mode, input string r);
        exp_t e;
        e.typ = t; e.runs = mode; e.ackc = 2 * mode;
        e.lockc = (mode == 2) ? 8 : 0; e.fltc = 4 * mode; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic wait_ack_low();
        do @(negedge clk); while (ack_n !== 1'b0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic run_intr(input logic [7:0] t, input bit dual, input string r);
        @(negedge clk);
        dual_mode = dual; good_type = t; need_runs = dual ? 2 : 1;
        push_exp(t, dual ? 2 : 1, r);
        intr_in = 1'b1;
        wait_ack_low();
        intr_in = 1'b0;
        drain();
    endtask

    // Monitor: accumulate per-vector cycle counts, pop and compare on valid.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ack_n) mon_ack++;
            if (!lock_n) mon_lock++;
            if (addr_float) mon_flt++;
            if (!ack_n && prev_ack) begin
                mon_runs++;
                total_falls++;
                if (exp_q.size() == 0) check(1'b0, "R3 unexpected acknowledge", 1, 0);
            end
            prev_ack = ack_n;
            if (vec_valid) begin
                check(!prev_valid, "R11 valid width", int'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected vector", int'(vec_type), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(vec_type == e.typ, {e.req, " type"}, int'(vec_type), int'(e.typ));
                    check(mon_runs == e.runs, {e.req, " acknowledge count"}, mon_runs, e.runs);
                    check(mon_ack == e.ackc, "R7 strobe clocks", mon_ack, e.ackc);
                    check(mon_lock == e.lockc, "R10 lock clocks", mon_lock, e.lockc);
                    check(mon_flt == e.fltc, "R6 float clocks", mon_flt, e.fltc);
                end
                mon_runs = 0; mon_ack = 0; mon_lock = 0; mon_flt = 0;
            end
            prev_valid = vec_valid;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 1, 0);
        finish_run();
    end

    initial begin
        int falls_before;
        repeat (3) @(negedge clk);
        check(ack_n === 1'b1, "R1 ack_n in reset", int'(ack_n), 1);
        check(lock_n === 1'b1, "R1 lock_n in reset", int'(lock_n), 1);
        check(addr_float === 1'b0, "R1 addr_float in reset", int'(addr_float), 0);
        check(vec_valid === 1'b0, "R1 vec_valid in reset", int'(vec_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: single cycle, type from the only cycle.
        run_intr(8'h4A, 1'b0, "R8");
        run_intr(8'hFF, 1'b0, "R8");
        // R9: double cycle, decoy on the first, type from the second.
        run_intr(8'h91, 1'b1, "R9");
        run_intr(8'h00, 1'b1, "R9");

        // R2: one-clock pulse, then a long level gives one vector.
        push_exp(8'd2, 0, "R2");
        nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
        drain();
        push_exp(8'd2, 0, "R2");
        nmi_in = 1'b1; repeat (20) @(negedge clk); nmi_in = 1'b0;
        drain();

        // R3: masked level request does nothing.
        falls_before = total_falls;
        ie_flag = 1'b0; intr_in = 1'b1;
        repeat (30) @(negedge clk);
        intr_in = 1'b0;
        repeat (6) @(negedge clk);
        ie_flag = 1'b1;
        check(total_falls == falls_before, "R3 masked request", total_falls - falls_before, 0);
        repeat (4) @(negedge clk);

        // R4: both together, non-maskable first.
        dual_mode = 1'b0; good_type = 8'h33; need_runs = 1;
        push_exp(8'd2, 0, "R4");
        push_exp(8'h33, 1, "R4");
        nmi_in = 1'b1; intr_in = 1'b1;
        wait_ack_low();
        intr_in = 1'b0; nmi_in = 1'b0;
        drain();

        // R5: short pulse during a locked sequence is held.
        dual_mode = 1'b1; good_type = 8'h5C; need_runs = 2;
        push_exp(8'h5C, 2, "R5");
        push_exp(8'd2, 0, "R5");
        intr_in = 1'b1;
        wait_ack_low();
        intr_in = 1'b0; nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        drain();

        check(exp_q.size() == 0, "R2 all vectors delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule